// File: doc/BRIEF.md
# Boot-Overlay Address Decoder for a 24-bit Bus

This block sits between a 68000-style processor bus and the memory and peripheral blocks of a small system. For every bus request it looks at the low 24 bits of the address, the direction and the transfer size. It then returns, one clock later, the outcome of the request. That outcome is a one-hot device select, a byte offset into RAM or ROM, a peripheral register index, a reset pulse for the serial controller, or an abnormal-access flag.

After reset a boot overlay is active. ROM answers reads at address zero so that the processor can fetch its reset vectors, and the low part of RAM is reachable through a window higher up. The first request of any kind that touches the ROM window at 0x400000 turns the overlay off. From then on RAM fills the bottom 4 MiB.

The block also folds three interrupt sources into a registered 3-bit processor priority level.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset `dev_sel`, `mem_offset`, `reg_index`, `ser_reset`, `bad_access` and `ipl` are all zero and `overlay_on` is 1. A cycle with `acc_req` low gives all-zero results in the following cycle.
- R2: Results of a request appear in the cycle after the edge that samples `acc_req`. `dev_sel` is one-hot or zero, with bit 0 RAM, bit 1 ROM, bit 2 parallel/timer, bit 3 serial, bit 4 floppy and bit 5 SCSI. `mem_offset` is zero unless RAM or ROM is selected, and `reg_index` is zero unless a peripheral is selected.
- R3: Address bits 31:24 have no effect on any result.
- R4: With the overlay on, a read below 0x100000 selects ROM with offset equal to the address. A write there, or any request in 0x100000–0x3FFFFF, is abnormal. A request in 0x600000–0x7FFFFF selects RAM with offset equal to the address minus 0x600000.
- R5: With the overlay off, any request below 0x400000 selects RAM with offset equal to the address, and requests in 0x600000–0x7FFFFF are abnormal.
- R6: A read in 0x400000–0x4FFFFF selects ROM with offset equal to address bits 19:0, and a write there is abnormal. Any request in that window, read or write, turns the overlay off from the next request on. Only reset turns the overlay on.
- R7: Parallel/timer window 0xE80000–0xEFFFFF: a byte request at an even address is selected with index equal to address bits 12:9. Any other request there is abnormal.
- R8: Serial window 0x800000–0xBFFFFF: a word request is abnormal. A byte read at an odd address gives a one-cycle `ser_reset` with no select and no abnormal flag. A byte write at an even address is abnormal. Otherwise the request is selected only if writes use 0xA00000–0xBFFFFF and reads use 0x800000–0x9FFFFF, with index equal to address bits 2:1. A request that passes the other checks but uses the wrong half is abnormal.
- R9: Floppy window 0xC00000–0xDFFFFF: a byte request at an odd address is selected with index equal to address bits 12:9. Any other request there is abnormal.
- R10: SCSI window 0x580000–0x5FFFFF: a byte write at an odd address or a byte read at an even address is selected with index equal to address bits 6:4. Any other request there is abnormal.
- R11: A request to an address in no window (0x500000–0x57FFFF, 0xE00000–0xE7FFFF, 0xF00000–0xFFFFFF) is abnormal. An abnormal request produces no select.
- R12: One cycle after the interrupt inputs are sampled, `ipl[0]` equals `irq_timer & ~irq_serial`, `ipl[1]` equals `irq_serial` and `ipl[2]` equals `irq_button`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; sets the overlay |
| acc_req | input | 1 | A bus request is present this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| acc_addr | input | 32 | Processor address; only bits 23:0 are decoded |
| irq_timer | input | 1 | Parallel/timer interrupt request |
| irq_serial | input | 1 | Serial controller interrupt request |
| irq_button | input | 1 | External interrupt button |
| dev_sel | output | 6 | One-hot device select (see R2) |
| mem_offset | output | 22 | Byte offset into RAM or ROM |
| reg_index | output | 4 | Peripheral register index |
| ser_reset | output | 1 | One-cycle serial controller reset pulse |
| bad_access | output | 1 | One-cycle abnormal-access flag |
| ipl | output | 3 | Processor priority level |
| overlay_on | output | 1 | Boot overlay currently active |

## Verification
Every decode result and the priority level are registered once. Each is due in the cycle that follows the clock edge at which the request or the interrupt levels were sampled. The overlay change caused by a ROM-window request shows at that same point. The bench applies stimulus on the falling edge, lets exactly one rising edge pass, and compares all outputs on the next falling edge. It drops `acc_req` before the next rising edge, so that a following idle cycle can show the pulse outputs returning to zero.

// File: rtl/ovd_pkg.sv
package ovd_pkg;

  localparam int DEC_W   = 24;
  localparam int RAM_AW  = 22;
  localparam int ROM_AW  = 20;
  localparam int MIR_AW  = 21;
  localparam int IDX_W   = 4;
  localparam int NSEL    = 6;

  localparam int SEL_RAM  = 0;
  localparam int SEL_ROM  = 1;
  localparam int SEL_PIO  = 2;
  localparam int SEL_SER  = 3;
  localparam int SEL_FLP  = 4;
  localparam int SEL_SCSI = 5;

  typedef enum logic [2:0] {
    RG_LOWMEM,
    RG_ROMWIN,
    RG_MIRROR,
    RG_PIO,
    RG_SER,
    RG_FLP,
    RG_SCSI,
    RG_NONE
  } region_e;

  // Window classification; the peripheral windows are tested first.
  function automatic region_e region_of(input logic [DEC_W-1:0] a);
    if (a[23:19] == 5'b11101)      return RG_PIO;
    else if (a[23:22] == 2'b10)    return RG_SER;
    else if (a[23:21] == 3'b110)   return RG_FLP;
    else if (a[23:19] == 5'b01011) return RG_SCSI;
    else if (a[23:22] == 2'b00)    return RG_LOWMEM;
    else if (a[23:20] == 4'h4)     return RG_ROMWIN;
    else if (a[23:21] == 3'b011)   return RG_MIRROR;
    else                           return RG_NONE;
  endfunction

  function automatic logic [IDX_W-1:0] wide_index(input logic [DEC_W-1:0] a);
    return a[12:9];
  endfunction

  function automatic logic [IDX_W-1:0] ser_index(input logic [DEC_W-1:0] a);
    return {{(IDX_W-2){1'b0}}, a[2:1]};
  endfunction

  function automatic logic [IDX_W-1:0] scsi_index(input logic [DEC_W-1:0] a);
    return {{(IDX_W-3){1'b0}}, a[6:4]};
  endfunction

  function automatic logic [NSEL-1:0] one_sel(input int pos);
    logic [NSEL-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/ovd_access_rules.sv
module ovd_access_rules
  import ovd_pkg::*;
(
  input  logic [DEC_W-1:0]  addr,
  input  logic              wr,
  input  logic              byte_acc,
  input  logic              overlay,
  output logic [NSEL-1:0]   sel_nxt,
  output logic [RAM_AW-1:0] ofs_nxt,
  output logic [IDX_W-1:0]  idx_nxt,
  output logic              srst_nxt,
  output logic              bad_nxt,
  output logic              rom_touch
);

  region_e rg;
  logic    odd;
  logic    wr_half;

  assign rg        = region_of(addr);
  assign odd       = addr[0];
  assign wr_half   = addr[21];
  assign rom_touch = (rg == RG_ROMWIN);

  always_comb begin
    sel_nxt  = '0;
    ofs_nxt  = '0;
    idx_nxt  = '0;
    srst_nxt = 1'b0;
    bad_nxt  = 1'b0;
    unique case (rg)
      RG_PIO: begin
        if (byte_acc && !odd) begin
          sel_nxt = one_sel(SEL_PIO);
          idx_nxt = wide_index(addr);
        end else begin
          bad_nxt = 1'b1;
        end
      end
      RG_SER: begin
        if (!byte_acc) begin
          bad_nxt = 1'b1;
        end else if (wr != odd) begin
          if (wr) bad_nxt  = 1'b1;
          else    srst_nxt = 1'b1;
        end else if (wr != wr_half) begin
          bad_nxt = 1'b1;
        end else begin
          sel_nxt = one_sel(SEL_SER);
          idx_nxt = ser_index(addr);
        end
      end
      RG_FLP: begin
        if (byte_acc && odd) begin
          sel_nxt = one_sel(SEL_FLP);
          idx_nxt = wide_index(addr);
        end else begin
          bad_nxt = 1'b1;
        end
      end
      RG_SCSI: begin
        if (byte_acc && (wr == odd)) begin
          sel_nxt = one_sel(SEL_SCSI);
          idx_nxt = scsi_index(addr);
        end else begin
          bad_nxt = 1'b1;
        end
      end
      RG_LOWMEM: begin
        if (!overlay) begin
          sel_nxt = one_sel(SEL_RAM);
          ofs_nxt = addr[RAM_AW-1:0];
        end else if (!wr && (addr[RAM_AW-1:ROM_AW] == '0)) begin
          sel_nxt = one_sel(SEL_ROM);
          ofs_nxt = {{(RAM_AW-ROM_AW){1'b0}}, addr[ROM_AW-1:0]};
        end else begin
          bad_nxt = 1'b1;
        end
      end
      RG_ROMWIN: begin
        if (!wr) begin
          sel_nxt = one_sel(SEL_ROM);
          ofs_nxt = {{(RAM_AW-ROM_AW){1'b0}}, addr[ROM_AW-1:0]};
        end else begin
          bad_nxt = 1'b1;
        end
      end
      RG_MIRROR: begin
        if (overlay) begin
          sel_nxt = one_sel(SEL_RAM);
          ofs_nxt = {{(RAM_AW-MIR_AW){1'b0}}, addr[MIR_AW-1:0]};
        end else begin
          bad_nxt = 1'b1;
        end
      end
      default: bad_nxt = 1'b1;
    endcase
  end

endmodule

// File: rtl/ovd_overlay_reg.sv
module ovd_overlay_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_evt,
  output logic overlay
);

  always_ff @(posedge clk) begin
    if (!rst_n)         overlay <= 1'b1;
    else if (clear_evt) overlay <= 1'b0;
  end

endmodule

// File: rtl/ovd_ipl_enc.sv
module ovd_ipl_enc #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_timer,
  input  logic             irq_serial,
  input  logic             irq_button,
  output logic [LVL_W-1:0] ipl
);

  function automatic logic [LVL_W-1:0] fold(input logic t, input logic s, input logic b);
    logic [LVL_W-1:0] v;
    v    = '0;
    v[0] = t & ~s;
    v[1] = s;
    v[2] = b;
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ipl <= '0;
    else        ipl <= fold(irq_timer, irq_serial, irq_button);
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import ovd_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic              acc_byte,
  input  logic [BUS_W-1:0]  acc_addr,
  input  logic              irq_timer,
  input  logic              irq_serial,
  input  logic              irq_button,
  output logic [NSEL-1:0]   dev_sel,
  output logic [RAM_AW-1:0] mem_offset,
  output logic [IDX_W-1:0]  reg_index,
  output logic              ser_reset,
  output logic              bad_access,
  output logic [2:0]        ipl,
  output logic              overlay_on
);

  logic [DEC_W-1:0]  dec_addr;
  logic [NSEL-1:0]   sel_nxt;
  logic [RAM_AW-1:0] ofs_nxt;
  logic [IDX_W-1:0]  idx_nxt;
  logic              srst_nxt;
  logic              bad_nxt;
  logic              rom_touch;
  logic              ovl_clear;
  logic              unused_hi;

  assign dec_addr  = acc_addr[DEC_W-1:0];
  assign unused_hi = ^acc_addr[BUS_W-1:DEC_W];
  assign ovl_clear = acc_req && rom_touch;

  ovd_access_rules u_rules (
    .addr     (dec_addr),
    .wr       (acc_wr),
    .byte_acc (acc_byte),
    .overlay  (overlay_on),
    .sel_nxt  (sel_nxt),
    .ofs_nxt  (ofs_nxt),
    .idx_nxt  (idx_nxt),
    .srst_nxt (srst_nxt),
    .bad_nxt  (bad_nxt),
    .rom_touch(rom_touch)
  );

  ovd_overlay_reg u_ovl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_evt(ovl_clear),
    .overlay  (overlay_on)
  );

  ovd_ipl_enc #(.LVL_W(3)) u_ipl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_timer (irq_timer),
    .irq_serial(irq_serial),
    .irq_button(irq_button),
    .ipl       (ipl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !acc_req) begin
      dev_sel    <= '0;
      mem_offset <= '0;
      reg_index  <= '0;
      ser_reset  <= 1'b0;
      bad_access <= 1'b0;
    end else begin
      dev_sel    <= sel_nxt;
      mem_offset <= ofs_nxt;
      reg_index  <= idx_nxt;
      ser_reset  <= srst_nxt;
      bad_access <= bad_nxt;
    end
  end

endmodule

// File: rtl/ovd_checker.sv
module ovd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_req,
  input logic        acc_wr,
  input logic [31:0] acc_addr,
  input logic        irq_timer,
  input logic        irq_serial,
  input logic        irq_button,
  input logic [5:0]  dev_sel,
  input logic [21:0] mem_offset,
  input logic [3:0]  reg_index,
  input logic        ser_reset,
  input logic        bad_access,
  input logic [2:0]  ipl,
  input logic        overlay_on,
  input logic        rom_touch
);

  // R1: idle cycle yields empty results
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> (dev_sel == '0 && !bad_access && !ser_reset && mem_offset == '0 && reg_index == '0));

  // R2: at most one device selected
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  // R2: offset only with a memory select, index only with a peripheral select
  p_ofs_mem_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_offset != '0) |-> (dev_sel[0] || dev_sel[1]));
  p_idx_per_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_index != '0) |-> (dev_sel[5:2] != '0));

  // R6: ROM window request turns the overlay off; nothing but reset turns it on
  p_ovl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && rom_touch) |=> !overlay_on);
  p_ovl_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_on |=> !overlay_on);

  // R6: a write never selects ROM
  p_no_rom_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr) |=> !dev_sel[1]);

  // R8: serial reset pulse excludes select and abnormal flag
  p_srst_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_reset |-> (dev_sel == '0 && !bad_access));

  // R11: abnormal request produces no select
  p_bad_nosel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> (dev_sel == '0));

  // R12: priority level follows the interrupt inputs one cycle later
  p_ipl_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ipl == {$past(irq_button), $past(irq_serial), $past(irq_timer) & ~$past(irq_serial)}));

  logic unused_chk;
  assign unused_chk = ^acc_addr;

endmodule

bind boot_overlay_decoder ovd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_req   (acc_req),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .irq_timer (irq_timer),
  .irq_serial(irq_serial),
  .irq_button(irq_button),
  .dev_sel   (dev_sel),
  .mem_offset(mem_offset),
  .reg_index (reg_index),
  .ser_reset (ser_reset),
  .bad_access(bad_access),
  .ipl       (ipl),
  .overlay_on(overlay_on),
  .rom_touch (rom_touch)
);

// File: tb/tb_boot_overlay_decoder.sv
`timescale 1ns/1ps
module tb_boot_overlay_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_req, acc_wr, acc_byte;
  logic [31:0] acc_addr;
  logic        irq_timer, irq_serial, irq_button;
  logic [5:0]  dev_sel;
  logic [21:0] mem_offset;
  logic [3:0]  reg_index;
  logic        ser_reset, bad_access, overlay_on;
  logic [2:0]  ipl;

  int n_chk = 0;
  int n_bad = 0;
  bit m_ovl;

  always #2.5 clk = ~clk;

  boot_overlay_decoder dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_byte(acc_byte), .acc_addr(acc_addr), .irq_timer(irq_timer),
    .irq_serial(irq_serial), .irq_button(irq_button), .dev_sel(dev_sel),
    .mem_offset(mem_offset), .reg_index(reg_index), .ser_reset(ser_reset),
    .bad_access(bad_access), .ipl(ipl), .overlay_on(overlay_on)
  );

  typedef struct packed {
    logic [5:0]  sel;
    logic [21:0] ofs;
    logic [3:0]  idx;
    logic        srst;
    logic        bad;
  } res_t;

  // Expected result built from address ranges (R2..R11)
  function automatic res_t model(input logic [31:0] full, input bit wr, input bit byt, input bit ovl);
    res_t r;
    int unsigned a;
    bit odd;
    r = '0;
    a = full & 32'h00FF_FFFF;
    odd = a[0];
    if (a >= 32'hE80000 && a < 32'hF00000) begin
      if (byt && !odd) begin r.sel = 6'b000100; r.idx = 4'((a >> 9) & 15); end
      else r.bad = 1;
    end else if (a >= 32'h800000 && a < 32'hC00000) begin
      if (!byt) r.bad = 1;
      else if (wr && !odd) r.bad = 1;
      else if (!wr && odd) r.srst = 1;
      else if (wr != (a >= 32'hA00000)) r.bad = 1;
      else begin r.sel = 6'b001000; r.idx = 4'((a >> 1) & 3); end
    end else if (a >= 32'hC00000 && a < 32'hE00000) begin
      if (byt && odd) begin r.sel = 6'b010000; r.idx = 4'((a >> 9) & 15); end
      else r.bad = 1;
    end else if (a >= 32'h580000 && a < 32'h600000) begin
      if (byt && (wr == odd)) begin r.sel = 6'b100000; r.idx = 4'((a >> 4) & 7); end
      else r.bad = 1;
    end else if (a < 32'h400000) begin
      if (!ovl) begin r.sel = 6'b000001; r.ofs = 22'(a); end
      else if (!wr && a < 32'h100000) begin r.sel = 6'b000010; r.ofs = 22'(a); end
      else r.bad = 1;
    end else if (a < 32'h500000) begin
      if (!wr) begin r.sel = 6'b000010; r.ofs = 22'(a - 32'h400000); end
      else r.bad = 1;
    end else if (a >= 32'h600000 && a < 32'h800000) begin
      if (ovl) begin r.sel = 6'b000001; r.ofs = 22'(a - 32'h600000); end
      else r.bad = 1;
    end else r.bad = 1;
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One request: drive at falling edge, one rising edge, compare at next falling edge
  task automatic access(input string req, input logic [31:0] a, input bit wr, input bit byt);
    res_t e;
    bit ovl_after;
    e = model(a, wr, byt, m_ovl);
    ovl_after = m_ovl && !((a & 32'hFFFFFF) >= 32'h400000 && (a & 32'hFFFFFF) < 32'h500000);
    acc_req = 1; acc_wr = wr; acc_byte = byt; acc_addr = a;
    @(negedge clk);
    acc_req = 0;
    m_ovl = ovl_after;
    check(req, "dev_sel",    64'(dev_sel),    64'(e.sel));
    check(req, "mem_offset", 64'(mem_offset), 64'(e.ofs));
    check(req, "reg_index",  64'(reg_index),  64'(e.idx));
    check(req, "ser_reset",  64'(ser_reset),  64'(e.srst));
    check(req, "bad_access", 64'(bad_access), 64'(e.bad));
    check(req, "overlay_on", 64'(overlay_on), 64'(m_ovl));
  endtask

  task automatic do_reset();
    rst_n = 0; acc_req = 0; acc_wr = 0; acc_byte = 0; acc_addr = '0;
    irq_timer = 0; irq_serial = 0; irq_button = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_ovl = 1;
  endtask

  task automatic t_reset_state();  // R1
    check("R1", "dev_sel",    64'(dev_sel), 0);
    check("R1", "mem_offset", 64'(mem_offset), 0);
    check("R1", "reg_index",  64'(reg_index), 0);
    check("R1", "ser_reset",  64'(ser_reset), 0);
    check("R1", "bad_access", 64'(bad_access), 0);
    check("R1", "ipl",        64'(ipl), 0);
    check("R1", "overlay_on", 64'(overlay_on), 1);
  endtask

  task automatic t_boot_overlay();  // R4
    access("R4", 32'h0000_0000, 0, 0);
    access("R4", 32'h000F_FFFE, 0, 1);
    access("R4", 32'h0000_1000, 1, 0);
    access("R4", 32'h0020_0000, 0, 0);
    access("R4", 32'h0060_0010, 1, 0);
    access("R4", 32'h007F_FFFF, 0, 1);
  endtask

  task automatic t_upper_bits();  // R3
    access("R3", 32'hFF00_0040, 0, 0);
    access("R3", 32'h5AE8_0200, 1, 1);
    access("R3", 32'hA5C0_1E01, 0, 1);
  endtask

  task automatic t_idle();  // R1
    @(negedge clk);
    check("R1", "idle dev_sel",    64'(dev_sel), 0);
    check("R1", "idle bad_access", 64'(bad_access), 0);
    check("R1", "idle ser_reset",  64'(ser_reset), 0);
  endtask

  task automatic t_rom_clear();  // R6, R5
    access("R6", 32'h0040_0000, 1, 0);
    access("R6", 32'h0044_5678, 0, 0);
    access("R5", 32'h0000_0000, 1, 0);
    access("R5", 32'h003F_FFFE, 0, 1);
    access("R5", 32'h0060_0010, 0, 0);
    access("R6", 32'h0000_0010, 0, 0);
  endtask

  task automatic t_pio();  // R7
    access("R7", 32'h00EF_E1FE, 0, 1);
    access("R7", 32'h00E8_1A00, 1, 1);
    access("R7", 32'h00EF_E1FF, 0, 1);
    access("R7", 32'h00EF_E1FE, 0, 0);
  endtask

  task automatic t_ser();  // R8
    access("R8", 32'h009F_FFF8, 0, 1);
    access("R8", 32'h009F_FFFC, 0, 1);
    access("R8", 32'h00BF_FFFB, 1, 1);
    access("R8", 32'h009F_FFF9, 0, 1);
    t_idle();
    access("R8", 32'h00BF_FFFA, 1, 1);
    access("R8", 32'h009F_FFFB, 1, 1);
    access("R8", 32'h00BF_FFF8, 0, 1);
    access("R8", 32'h009F_FFF8, 0, 0);
  endtask

  task automatic t_flp();  // R9
    access("R9", 32'h00DF_E1FF, 0, 1);
    access("R9", 32'h00C0_0401, 1, 1);
    access("R9", 32'h00DF_E1FE, 0, 1);
    access("R9", 32'h00DF_E1FF, 1, 0);
  endtask

  task automatic t_scsi();  // R10
    access("R10", 32'h0058_0070, 0, 1);
    access("R10", 32'h005F_FF51, 1, 1);
    access("R10", 32'h0058_0071, 0, 1);
    access("R10", 32'h0058_0060, 1, 1);
    access("R10", 32'h0058_0060, 0, 0);
  endtask

  task automatic t_unmapped();  // R11
    access("R11", 32'h0050_0000, 0, 1);
    access("R11", 32'h00E0_0000, 0, 1);
    access("R11", 32'h00F4_0000, 1, 0);
    access("R11", 32'h00FF_FFF0, 0, 0);
  endtask

  task automatic t_ipl();  // R12
    for (int v = 0; v < 8; v++) begin
      irq_timer = v[0]; irq_serial = v[1]; irq_button = v[2];
      @(negedge clk);
      check("R12", "ipl", 64'(ipl), 64'({v[2], v[1], v[0] & ~v[1]}));
    end
    irq_timer = 0; irq_serial = 0; irq_button = 0;
  endtask

  task automatic t_reset_again();  // R6: only reset restores the overlay
    do_reset();
    check("R6", "overlay after reset", 64'(overlay_on), 1);
    access("R4", 32'h0000_0100, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_idle();
    t_boot_overlay();
    t_upper_bits();
    t_pio();
    t_ser();
    t_flp();
    t_scsi();
    t_unmapped();
    t_rom_clear();
    t_ipl();
    t_reset_again();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule